// File: doc/BRIEF.md
# LIN Master Frame Transmitter

This block is the transmit side of a serial port that can also act as the master of a LIN bus. In master mode it waits for a start request. It then pulls the line low for a break of programmable length and releases it high for one bit time. After that it sends every byte queued in an external transmit FIFO as an 8N1 character. Software queues the bytes in this order: the sync byte 0x55, the identifier, the data bytes and the checksum. The block pops one entry for each character and ends the frame when the FIFO runs dry.

With master mode off, the block is a plain serial transmitter. It sends whatever the FIFO holds, with no break and no start request. A one-clock baud enable from outside sets every bit time. The FIFO is show-ahead: the head entry is always on the read-data input, and a one-cycle read strobe removes it.

Top module: `lin_master_tx`

## Requirements
- R1: Each character is one start bit (low), eight data bits sent least significant bit first, and one stop bit (high). No parity bit is sent. Every bit lasts exactly one baud-enable period.
- R2: In master mode, an accepted start request drives the line low from the next clock. The line stays low for 13 + `brk_len_i` baud periods, so code 0 gives 13 and code 3 gives 16. The length is taken at the moment the request is accepted, and later changes to `brk_len_i` do not alter that break.
- R3: After the break, the line is high for exactly one baud period. Then the start bit of the first character begins.
- R4: In a master frame, the characters go out back to back, one FIFO entry each, in FIFO order. The first entry (the sync byte 0x55) comes right after the delimiter, then the identifier, the data and the checksum. The FIFO is never read while it is empty.
- R5: In master mode, a start request is ignored while the FIFO holds fewer than two entries. The line stays high, busy stays low and no entry is read.
- R6: With master mode off, the block sends the queued bytes as soon as the FIFO is not empty, with no break and no delimiter, and it needs no start request.
- R7: When the stop bit of a character ends with the FIFO empty, the frame ends. Done is high for exactly one clock, busy falls in that same clock, and the line is idle high.
- R8: After reset, and at all times when busy is low, the line is high and done is low.
- R9: In master mode with no start request, queued bytes stay in the FIFO and the line stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-clock pulse marking the end of each bit time |
| master_en_i | input | 1 | 1 selects LIN master framing, 0 selects plain transmit |
| brk_len_i | input | 2 | Break length code; break is 13 + code bit times |
| start_i | input | 1 | Request to begin a master frame |
| fifo_empty_i | input | 1 | Transmit FIFO has no entries |
| fifo_count_i | input | CNT_W (5) | Number of entries in the transmit FIFO |
| fifo_rdata_i | input | 8 | Head entry of the show-ahead FIFO |
| fifo_rd_o | output | 1 | Removes the head entry at this clock edge |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | High while a frame or character stream is in progress |
| done_o | output | 1 | One-clock pulse at the end of a frame |

## Verification
The assertions check, on every cycle, the rules that need no memory of the frame. The line moves only on a baud enable or when sending begins. An idle line is high. Done lasts a single clock. The FIFO is never read when empty. A short-FIFO request never sets busy. The entry into a break, or into a plain start bit, follows in the next clock. Only the bench's scenarios can show the whole bit sequence of a frame against a reference built from the queued bytes: the exact break length for each code, including a code changed in the middle of the break, the single delimiter bit, least-significant-bit-first order and the byte order. They also show that a refused start leaves the FIFO untouched and that a queued master frame waits for its start request.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BREAK = 2'd1,
        ST_DELIM = 2'd2,
        ST_CHAR  = 2'd3
    } tx_state_e;

    localparam int FRAME_OVERHEAD_BITS = 2;

endpackage

// File: rtl/lin_tx_launch.sv
module lin_tx_launch #(
    parameter int CNT_W           = 5,
    parameter int MIN_HDR_ENTRIES = 2
) (
    input  logic             idle_i,
    input  logic             master_en_i,
    input  logic             start_i,
    input  logic             fifo_empty_i,
    input  logic [CNT_W-1:0] fifo_count_i,
    output logic             hdr_go_o,
    output logic             plain_go_o
);
    logic enough_entries;

    always_comb begin
        enough_entries = (fifo_count_i >= CNT_W'(MIN_HDR_ENTRIES));
        hdr_go_o       = idle_i && master_en_i && start_i && enough_entries;
        plain_go_o     = idle_i && !master_en_i && !fifo_empty_i;
    end

endmodule

// File: rtl/lin_tx_shifter.sv
module lin_tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              bit_o
);
    localparam int SH_W = DATA_W + lin_tx_pkg::FRAME_OVERHEAD_BITS;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d = {1'b1, data_i, 1'b0};
        end else if (shift_i) begin
            sh_d = {1'b1, sh_q[SH_W-1:1]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign bit_o = sh_q[0];

endmodule

// File: rtl/lin_tx_fsm.sv
module lin_tx_fsm
    import lin_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BLEN_W     = 2,
    parameter int BREAK_BASE = 13
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              hdr_go_i,
    input  logic              plain_go_i,
    input  logic [BLEN_W-1:0] brk_len_i,
    input  logic              fifo_empty_i,
    output tx_state_e         state_o,
    output logic              load_o,
    output logic              shift_o,
    output logic              pop_o,
    output logic              done_o
);
    localparam int CHAR_BITS = DATA_W + FRAME_OVERHEAD_BITS;
    localparam int MAX_BRK   = BREAK_BASE + (1 << BLEN_W);
    localparam int CNT_MAX   = (MAX_BRK > CHAR_BITS) ? MAX_BRK : CHAR_BITS;
    localparam int CW        = $clog2(CNT_MAX + 1);

    typedef struct packed {
        tx_state_e     state;
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
        logic          done;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic load_d, shift_d, pop_d;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.done = 1'b0;
        load_d     = 1'b0;
        shift_d    = 1'b0;
        pop_d      = 1'b0;
        unique case (fsm_q.state)
            ST_IDLE: begin
                if (hdr_go_i) begin
                    fsm_d.state = ST_BREAK;
                    fsm_d.cnt   = '0;
                    fsm_d.lim   = CW'(BREAK_BASE - 1) + CW'(brk_len_i);
                end else if (plain_go_i) begin
                    pop_d       = 1'b1;
                    load_d      = 1'b1;
                    fsm_d.state = ST_CHAR;
                    fsm_d.cnt   = '0;
                end
            end
            ST_BREAK: begin
                if (tick_i) begin
                    if (fsm_q.cnt == fsm_q.lim) begin
                        fsm_d.state = ST_DELIM;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
            end
            ST_DELIM: begin
                if (tick_i) begin
                    if (fifo_empty_i) begin
                        fsm_d.state = ST_IDLE;
                        fsm_d.done  = 1'b1;
                    end else begin
                        pop_d       = 1'b1;
                        load_d      = 1'b1;
                        fsm_d.state = ST_CHAR;
                        fsm_d.cnt   = '0;
                    end
                end
            end
            ST_CHAR: begin
                if (tick_i) begin
                    if (fsm_q.cnt == CW'(CHAR_BITS - 1)) begin
                        if (fifo_empty_i) begin
                            fsm_d.state = ST_IDLE;
                            fsm_d.done  = 1'b1;
                        end else begin
                            pop_d     = 1'b1;
                            load_d    = 1'b1;
                            fsm_d.cnt = '0;
                        end
                    end else begin
                        shift_d   = 1'b1;
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
            end
            default: fsm_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{state: ST_IDLE, cnt: '0, lim: '0, done: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.state;
    assign load_o  = load_d;
    assign shift_o = shift_d;
    assign pop_o   = pop_d;
    assign done_o  = fsm_q.done;

endmodule

// File: rtl/lin_master_tx.sv
module lin_master_tx
    import lin_tx_pkg::*;
#(
    parameter int DATA_W          = 8,
    parameter int CNT_W           = 5,
    parameter int BLEN_W          = 2,
    parameter int BREAK_BASE      = 13,
    parameter int MIN_HDR_ENTRIES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              baud_tick_i,
    input  logic              master_en_i,
    input  logic [BLEN_W-1:0] brk_len_i,
    input  logic              start_i,
    input  logic              fifo_empty_i,
    input  logic [CNT_W-1:0]  fifo_count_i,
    input  logic [DATA_W-1:0] fifo_rdata_i,
    output logic              fifo_rd_o,
    output logic              tx_o,
    output logic              busy_o,
    output logic              done_o
);
    tx_state_e state;
    logic      hdr_go, plain_go;
    logic      load, shift, ser_bit;

    lin_tx_launch #(
        .CNT_W           (CNT_W),
        .MIN_HDR_ENTRIES (MIN_HDR_ENTRIES)
    ) u_launch (
        .idle_i       (state == ST_IDLE),
        .master_en_i  (master_en_i),
        .start_i      (start_i),
        .fifo_empty_i (fifo_empty_i),
        .fifo_count_i (fifo_count_i),
        .hdr_go_o     (hdr_go),
        .plain_go_o   (plain_go)
    );

    lin_tx_fsm #(
        .DATA_W     (DATA_W),
        .BLEN_W     (BLEN_W),
        .BREAK_BASE (BREAK_BASE)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (baud_tick_i),
        .hdr_go_i     (hdr_go),
        .plain_go_i   (plain_go),
        .brk_len_i    (brk_len_i),
        .fifo_empty_i (fifo_empty_i),
        .state_o      (state),
        .load_o       (load),
        .shift_o      (shift),
        .pop_o        (fifo_rd_o),
        .done_o       (done_o)
    );

    lin_tx_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load),
        .shift_i (shift),
        .data_i  (fifo_rdata_i),
        .bit_o   (ser_bit)
    );

    always_comb begin
        unique case (state)
            ST_BREAK: tx_o = 1'b0;
            ST_CHAR:  tx_o = ser_bit;
            default:  tx_o = 1'b1;
        endcase
        busy_o = (state != ST_IDLE);
    end

endmodule

// File: rtl/lin_master_tx_chk.sv
module lin_master_tx_chk #(
    parameter int CNT_W           = 5,
    parameter int MIN_HDR_ENTRIES = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             baud_tick_i,
    input logic             master_en_i,
    input logic             start_i,
    input logic             fifo_empty_i,
    input logic [CNT_W-1:0] fifo_count_i,
    input logic             fifo_rd_o,
    input logic             tx_o,
    input logic             busy_o,
    input logic             done_o
);
    AST_POP_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_rd_o |-> !fifo_empty_i); // R4

    AST_SHORT_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (master_en_i && start_i && !busy_o && fifo_count_i < CNT_W'(MIN_HDR_ENTRIES)) |=> !busy_o); // R5

    AST_BREAK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (master_en_i && start_i && !busy_o && fifo_count_i >= CNT_W'(MIN_HDR_ENTRIES)) |=> (busy_o && !tx_o)); // R2

    AST_PLAIN_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!master_en_i && !busy_o && !fifo_empty_i) |=> (busy_o && !tx_o)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R7

    AST_DONE_LINE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (tx_o && !busy_o)); // R7

    AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> tx_o); // R8

    AST_MASTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (master_en_i && !busy_o) |-> !fifo_rd_o); // R9

    AST_BIT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(tx_o) |-> ($past(baud_tick_i) || !$past(busy_o))); // R1

endmodule

bind lin_master_tx lin_master_tx_chk #(
    .CNT_W           (CNT_W),
    .MIN_HDR_ENTRIES (MIN_HDR_ENTRIES)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .baud_tick_i  (baud_tick_i),
    .master_en_i  (master_en_i),
    .start_i      (start_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_count_i (fifo_count_i),
    .fifo_rd_o    (fifo_rd_o),
    .tx_o         (tx_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/tb_lin_master_tx.sv
module tb_lin_master_tx;
    localparam int CNT_W    = 5;
    localparam int TICK_DIV = 4;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       baud_tick_i = 1'b0;
    logic       master_en_i = 1'b0;
    logic [1:0] brk_len_i = 2'd0;
    logic       start_i = 1'b0;
    logic       fifo_empty_i;
    logic [CNT_W-1:0] fifo_count_i;
    logic [7:0] fifo_rdata_i;
    logic       fifo_rd_o, tx_o, busy_o, done_o;

    always #5 clk_i = ~clk_i;

    lin_master_tx dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .baud_tick_i(baud_tick_i),
        .master_en_i(master_en_i), .brk_len_i(brk_len_i), .start_i(start_i),
        .fifo_empty_i(fifo_empty_i), .fifo_count_i(fifo_count_i),
        .fifo_rdata_i(fifo_rdata_i), .fifo_rd_o(fifo_rd_o), .tx_o(tx_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    // show-ahead FIFO model
    logic [7:0] mem [0:63];
    int unsigned wr_ptr = 0;
    int unsigned rd_ptr = 0;
    always @(posedge clk_i) if (fifo_rd_o) rd_ptr <= rd_ptr + 1;
    assign fifo_empty_i = (rd_ptr == wr_ptr);
    assign fifo_count_i = CNT_W'(wr_ptr - rd_ptr);
    assign fifo_rdata_i = mem[rd_ptr % 64];

    // baud enable generator
    int div = 0;
    always @(posedge clk_i) begin
        div         <= (div == TICK_DIV - 1) ? 0 : div + 1;
        baud_tick_i <= (div == TICK_DIV - 2);
    end

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always @(posedge clk_i) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    logic [7:0] frame [0:15];
    bit exp_bits [0:511];
    bit got_bits [0:511];
    int exp_n, got_n;

    function automatic logic [7:0] lin_sum(input int first, input int n);
        int s = 0;
        for (int k = first; k < first + n; k++) begin
            s = s + int'(frame[k]);
            if (s > 255) s = s - 255;
        end
        return ~8'(s);
    endfunction

    task automatic build_exp(input bit hdr, input int blen, input int nb);
        exp_n = 0;
        if (hdr) begin
            for (int k = 0; k < 13 + blen; k++) begin
                exp_bits[exp_n] = 1'b0; exp_n++;
            end
            exp_bits[exp_n] = 1'b1; exp_n++;
        end
        for (int b = 0; b < nb; b++) begin
            exp_bits[exp_n] = 1'b0; exp_n++;
            for (int j = 0; j < 8; j++) begin
                exp_bits[exp_n] = frame[b][j]; exp_n++;
            end
            exp_bits[exp_n] = 1'b1; exp_n++;
        end
    endtask

    task automatic load_fifo(input int nb);
        @(negedge clk_i);
        for (int k = 0; k < nb; k++) mem[(wr_ptr + k) % 64] = frame[k];
        wr_ptr = wr_ptr + nb;
    endtask

    // Called at the negedge right after transmission began.
    task automatic capture(input int alt_blen, output bit saw_done, output bit busy_ok);
        got_n = 0; saw_done = 0; busy_ok = 1;
        for (int i = 0; i < 3000; i++) begin
            if (done_o) begin saw_done = 1; break; end
            if (i == 3 && alt_blen >= 0) brk_len_i = 2'(alt_blen);
            if (baud_tick_i) begin
                if (got_n < 512) got_bits[got_n] = tx_o;
                got_n++;
                if (!busy_o) busy_ok = 0;
            end
            @(negedge clk_i);
        end
    endtask

    task automatic compare_frame(input bit hdr, input int blen, input int nb);
        int bad_idx = -1;
        string req;
        build_exp(hdr, blen, nb);
        check(got_n == exp_n, hdr ? "R2" : "R6", "frame bit count", got_n, exp_n);
        for (int k = 0; k < exp_n && k < got_n; k++)
            if (bad_idx < 0 && got_bits[k] != exp_bits[k]) bad_idx = k;
        if (!hdr)                       req = "R6";
        else if (bad_idx < 13 + blen)   req = "R2";
        else if (bad_idx == 13 + blen)  req = "R3";
        else                            req = "R1/R4";
        check(bad_idx < 0, req, $sformatf("line bit %0d", bad_idx),
              (bad_idx < 0) ? 0 : int'(got_bits[bad_idx]),
              (bad_idx < 0) ? 0 : int'(exp_bits[bad_idx]));
    endtask

    task automatic finish_checks(input bit saw_done, input bit busy_ok);
        check(saw_done, "R7", "done seen", int'(saw_done), 1);
        check(busy_ok, "R8", "busy through frame", int'(busy_ok), 1);
        check(!busy_o && tx_o, "R7", "idle after done", int'({busy_o, tx_o}), 1);
        @(negedge clk_i);
        check(!done_o, "R7", "done width one clock", int'(done_o), 0);
        check(rd_ptr == wr_ptr, "R4", "fifo drained", int'(wr_ptr - rd_ptr), 0);
    endtask

    task automatic master_frame(input int nb, input int blen, input int alt);
        bit sd, bo;
        brk_len_i   = 2'(blen);
        master_en_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        capture(alt, sd, bo);
        compare_frame(1'b1, blen, nb);
        finish_checks(sd, bo);
    endtask

    task automatic make_frame(input int ndata);
        frame[0] = 8'h55;
        frame[1] = 8'($urandom_range(0, 255));
        for (int k = 0; k < ndata; k++) frame[2 + k] = 8'($urandom_range(0, 255));
        frame[2 + ndata] = lin_sum(1, ndata + 1);
    endtask

    initial begin
        bit sd, bo;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R8: reset state
        check(tx_o == 1'b1, "R8", "tx after reset", int'(tx_o), 1);
        check(!busy_o && !done_o, "R8", "busy/done after reset", int'({busy_o, done_o}), 0);

        // R5: start with a single entry is ignored
        master_en_i = 1'b1;
        frame[0] = 8'h55;
        load_fifo(1);
        @(negedge clk_i); start_i = 1'b1;
        @(negedge clk_i); start_i = 1'b0;
        bo = 1;
        for (int i = 0; i < 40; i++) begin
            if (busy_o || !tx_o) bo = 0;
            @(negedge clk_i);
        end
        check(bo, "R5", "line idle after short start", int'(bo), 1);
        check(fifo_count_i == 1, "R5", "fifo untouched", int'(fifo_count_i), 1);

        // header-only frame: sync already queued, add identifier (R3, R4)
        frame[0] = 8'h3C;
        load_fifo(1);
        frame[0] = 8'h55; frame[1] = 8'h3C;
        master_frame(2, 0, -1);

        // R9: queued master frame waits for start
        make_frame(3);
        load_fifo(6);
        bo = 1;
        for (int i = 0; i < 40; i++) begin
            if (busy_o || !tx_o) bo = 0;
            @(negedge clk_i);
        end
        check(bo, "R9", "no send without start", int'(bo), 1);
        check(fifo_count_i == 6, "R9", "fifo held", int'(fifo_count_i), 6);
        master_frame(6, 3, -1);

        // R2: break boundaries with mid-break code change
        make_frame(2); load_fifo(5); master_frame(5, 0, 3);
        make_frame(2); load_fifo(5); master_frame(5, 3, 0);

        // R6: plain transmit, no break, no start request
        master_en_i = 1'b0;
        for (int k = 0; k < 3; k++) frame[k] = 8'($urandom_range(0, 255));
        frame[0] = 8'h80;
        load_fifo(3);
        @(negedge clk_i);
        capture(-1, sd, bo);
        compare_frame(1'b0, 0, 3);
        finish_checks(sd, bo);

        // random master frames (R1, R2, R4)
        for (int f = 0; f < 20; f++) begin
            int nd = $urandom_range(0, 8);
            int bl = $urandom_range(0, 3);
            int al = $urandom_range(0, 3);
            make_frame(nd);
            load_fifo(nd + 3);
            master_frame(nd + 3, bl, al);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule